// File: doc/BRIEF.md
# Write-Leveling Edge Search Controller

The controller searches, for each of eight byte lanes, the strobe delay at which a fed-back sample bit changes from low to high. Each lane's delay is a composite setting of four fields: a phase step, a tap, a clock step and a coarse bit. A start pulse loads one initial setting per lane and latches the clock grade. The search then runs in two sweeps. In the first sweep every lane whose sample is not solidly low steps its delay down, until every lane reads low. In the second sweep every lane that is not solidly high steps its delay up, until every lane reads high. Because the second sweep always begins on a low reading, each lane ends on a real rising edge.

Each measurement fires five sample requests. Each request is followed by a settle wait, and the bit from each request is tallied per lane. Every change of a lane's delay also appears as a one-cycle step pulse for the external delay line. After the second sweep the final strobe settings are copied and stepped up by a fixed count that depends on the clock grade. The result is the data delay. Done then pulses. A step that would leave the legal range stops the run with an error.

Top module: `wlEdgeSearch`

## Requirements
- R1: After reset, done, error, sampleReq and all step pulses are low, and the strobe and data outputs are zero.
- R2: One measurement is 5 sample requests, each a one-cycle pulse. Consecutive requests are SETTLE_CYC+1 cycles apart. The sample bit is read SETTLE_CYC cycles after its request.
- R3: In the first sweep, a lane not yet finished whose tally is 0 finishes. Every other unfinished lane steps down one position per measurement. The sweep ends when all lanes are finished. Only stepDn pulses occur in this sweep.
- R4: The second sweep starts with all lanes unfinished. A lane whose tally is 5 finishes, and any tally below 5 (including a mixed tally) steps the lane up. Only stepUp pulses occur in this sweep.
- R5: Setting layout per lane is bit 9 coarse, bits 8:7 clock step (0..2), bits 6:3 tap (0..T), bits 2:0 phase (0..6). T is 12, 10 or 13 for grade 0, 1 or 2, and grade 3 behaves as grade 0. The position is (clock + 2·coarse)·(T+1)·7 + tap·7 + phase. One step up or down moves the position by exactly one.
- R6: A required step down from position 0 in the first sweep sets error and done never pulses.
- R7: A required step up from the top position (coarse 1, clock 2, tap T, phase 6) in the second sweep sets error.
- R8: On success the data delay position equals the final strobe position plus 39, 32 or 42 for grade 0, 1 or 2.
- R9: If that data offset would pass the top position, error is set instead of done.
- R10: Done is high for exactly one cycle. Error stays high until the next start, which clears it, and error and done are never high together.
- R11: Every change of a lane's strobe setting is reported by exactly one one-cycle step pulse in its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load initial settings and begin the search (honoured when idle) |
| gradeSel | input | 2 | Clock grade, latched at start |
| initDly | input | LANES*10 | Initial strobe setting per lane |
| sampleBits | input | LANES | Fed-back sample bit per lane |
| sampleReq | output | 1 | Sample request pulse |
| stepUp | output | LANES | Per-lane step-up pulse to the delay line |
| stepDn | output | LANES | Per-lane step-down pulse to the delay line |
| strobeDly | output | LANES*10 | Current strobe setting per lane |
| dataDly | output | LANES*10 | Derived data setting per lane |
| done | output | 1 | Search finished successfully (one cycle) |
| error | output | 1 | Search aborted on a range violation |

## Verification
The field-range assertion assumes that every initial setting loaded at start is legal for the selected grade: phase at most 6, tap at most T, and coarse 1 never combined with clock step 0 below tap T. The bench builds every initial setting from a legal position, so it stays inside that assumption. The sweep-direction assertions assume the sample bit comes from a delay line that moves only on the step pulses. The bench meets this with a lane model that tracks a position counter changed only by those pulses. From that counter the model drives a clean threshold bit, or on jitter lanes an alternating bit at the threshold position.

// File: rtl/wlSearchPkg.sv
package wlSearchPkg;
  localparam int PI_W  = 3;
  localparam int TAP_W = 4;
  localparam int CLK_W = 2;
  localparam logic [PI_W-1:0]  PI_TOP  = 3'd6;
  localparam logic [CLK_W-1:0] CLK_TOP = 2'd2;

  typedef struct packed {
    logic             coarse;
    logic [CLK_W-1:0] clkDly;
    logic [TAP_W-1:0] tap;
    logic [PI_W-1:0]  pi;
  } dlySet_t;

  localparam int SET_W = $bits(dlySet_t);

  typedef struct packed {
    logic load;
    logic capture;
    logic eval;
    logic passHi;
    logic clrDone;
    logic copyData;
    logic offStep;
  } ctrlStrb_t;

  // One position later; ovf set (and setting kept) at the top position.
  function automatic dlySet_t stepUpFn(input dlySet_t s, input logic [TAP_W-1:0] tapTop,
                                       output logic ovf);
    dlySet_t r;
    r   = s;
    ovf = 1'b0;
    if (s.pi < PI_TOP) begin
      r.pi = s.pi + 1'b1;
    end else if (s.tap < tapTop) begin
      r.pi  = '0;
      r.tap = s.tap + 1'b1;
    end else if (s.clkDly < CLK_TOP) begin
      r.pi     = '0;
      r.tap    = '0;
      r.clkDly = s.clkDly + 1'b1;
    end else if (!s.coarse) begin
      r.pi     = '0;
      r.tap    = '0;
      r.clkDly = s.clkDly - 1'b1;
      r.coarse = 1'b1;
    end else begin
      ovf = 1'b1;
    end
    return r;
  endfunction

  // One position earlier; unf set (and setting kept) at position zero.
  function automatic dlySet_t stepDnFn(input dlySet_t s, input logic [TAP_W-1:0] tapTop,
                                       output logic unf);
    dlySet_t r;
    r   = s;
    unf = 1'b0;
    if (s.pi != '0) begin
      r.pi = s.pi - 1'b1;
    end else if (s.tap != '0) begin
      r.pi  = PI_TOP;
      r.tap = s.tap - 1'b1;
    end else if (s.clkDly != '0) begin
      r.pi     = PI_TOP;
      r.tap    = tapTop;
      r.clkDly = s.clkDly - 1'b1;
    end else if (s.coarse) begin
      r.pi     = PI_TOP;
      r.tap    = tapTop;
      r.clkDly = s.clkDly + 1'b1;
      r.coarse = 1'b0;
    end else begin
      unf = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/wlSearchDp.sv
module wlSearchDp
  import wlSearchPkg::*;
#(
  parameter int LANES   = 8,
  parameter int SAMPLES = 5,
  parameter int OFF_W   = 6,
  parameter int OFF0    = 39,
  parameter int OFF1    = 32,
  parameter int OFF2    = 42,
  parameter int MT0     = 12,
  parameter int MT1     = 10,
  parameter int MT2     = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrb_t              strb,
  input  logic [1:0]             gradeSel,
  input  logic [LANES*SET_W-1:0] initFlat,
  input  logic [LANES-1:0]       sampleBits,
  output logic                   allDone,
  output logic                   fault,
  output logic [OFF_W-1:0]       offLen,
  output logic [LANES-1:0]       stepUp,
  output logic [LANES-1:0]       stepDn,
  output logic [LANES*SET_W-1:0] strobeFlat,
  output logic [LANES*SET_W-1:0] dataFlat
);
  localparam int CNT_W = $clog2(SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLES);

  logic [1:0]       gradeQ;
  logic [TAP_W-1:0] tapTop;
  logic [LANES-1:0] doneVec;
  logic [LANES-1:0] laneFault;
  logic             faultQ;

  always_comb begin
    unique case (gradeQ)
      2'd1:    begin tapTop = TAP_W'(MT1); offLen = OFF_W'(OFF1); end
      2'd2:    begin tapTop = TAP_W'(MT2); offLen = OFF_W'(OFF2); end
      default: begin tapTop = TAP_W'(MT0); offLen = OFF_W'(OFF0); end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gradeQ <= '0;
      faultQ <= 1'b0;
    end else if (strb.load) begin
      gradeQ <= gradeSel;
      faultQ <= 1'b0;
    end else if (|laneFault) begin
      faultQ <= 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    dlySet_t          strobeQ, dataQ, upNext, dnNext, datNext;
    logic             upOvf, dnUnf, datOvf;
    logic [CNT_W-1:0] cntQ;
    logic             doneQ, upQ, dnQ, needUp, needDn;

    always_comb begin
      upNext  = stepUpFn(strobeQ, tapTop, upOvf);
      dnNext  = stepDnFn(strobeQ, tapTop, dnUnf);
      datNext = stepUpFn(dataQ, tapTop, datOvf);
      needUp  = strb.eval && strb.passHi && !doneQ && (cntQ != CNT_FULL);
      needDn  = strb.eval && !strb.passHi && !doneQ && (cntQ != '0);
      laneFault[g] = (needUp && upOvf) || (needDn && dnUnf) || (strb.offStep && datOvf);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        strobeQ <= '0;
        dataQ   <= '0;
        cntQ    <= '0;
        doneQ   <= 1'b0;
        upQ     <= 1'b0;
        dnQ     <= 1'b0;
      end else begin
        upQ <= 1'b0;
        dnQ <= 1'b0;
        if (strb.load) begin
          strobeQ <= dlySet_t'(initFlat[g*SET_W +: SET_W]);
          dataQ   <= '0;
          cntQ    <= '0;
          doneQ   <= 1'b0;
        end else begin
          if (strb.capture) cntQ <= cntQ + CNT_W'(sampleBits[g]);
          if (strb.eval) begin
            cntQ <= '0;
            if (!doneQ) doneQ <= strb.passHi ? (cntQ == CNT_FULL) : (cntQ == '0);
          end
          if (needUp && !upOvf) begin
            strobeQ <= upNext;
            upQ     <= 1'b1;
          end
          if (needDn && !dnUnf) begin
            strobeQ <= dnNext;
            dnQ     <= 1'b1;
          end
          if (strb.clrDone) doneQ <= 1'b0;
          if (strb.copyData) dataQ <= strobeQ;
          if (strb.offStep && !datOvf) dataQ <= datNext;
        end
      end
    end

    assign doneVec[g] = doneQ;
    assign stepUp[g]  = upQ;
    assign stepDn[g]  = dnQ;
    assign strobeFlat[g*SET_W +: SET_W] = strobeQ;
    assign dataFlat[g*SET_W +: SET_W]   = dataQ;

    // R5
    legal_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobeQ.pi <= PI_TOP) && (strobeQ.tap <= tapTop) && (strobeQ.clkDly <= CLK_TOP));
  end

  assign allDone = &doneVec;
  assign fault   = faultQ;

  // R3
  down_in_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stepDn) |-> !strb.passHi);

  // R4
  up_in_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stepUp) |-> strb.passHi);
endmodule

// File: rtl/wlSearchCtrl.sv
module wlSearchCtrl
  import wlSearchPkg::*;
#(
  parameter int SAMPLES    = 5,
  parameter int SETTLE_CYC = 1250,
  parameter int OFF_W      = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             allDone,
  input  logic             fault,
  input  logic [OFF_W-1:0] offLen,
  output ctrlStrb_t        strb,
  output logic             sampleReq,
  output logic             done,
  output logic             error
);
  localparam int TMR_W  = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int SIDX_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_EVAL, ST_CHECK, ST_OFFS, ST_FIN} st_t;

  st_t               stateQ;
  logic              passQ, errQ;
  logic [TMR_W-1:0]  tmrQ;
  logic [SIDX_W-1:0] sIdxQ;
  logic [OFF_W-1:0]  offCntQ;
  logic              sweepEnd;

  assign sweepEnd = (stateQ == ST_CHECK) && !fault && allDone;

  always_comb begin
    strb.load     = (stateQ == ST_IDLE) && start;
    strb.capture  = (stateQ == ST_WAIT) && (tmrQ == '0);
    strb.eval     = (stateQ == ST_EVAL);
    strb.passHi   = passQ;
    strb.clrDone  = sweepEnd && !passQ;
    strb.copyData = sweepEnd && passQ;
    strb.offStep  = (stateQ == ST_OFFS) && (offCntQ != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      passQ   <= 1'b0;
      errQ    <= 1'b0;
      tmrQ    <= '0;
      sIdxQ   <= '0;
      offCntQ <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (start) begin
          passQ  <= 1'b0;
          errQ   <= 1'b0;
          sIdxQ  <= '0;
          stateQ <= ST_REQ;
        end
        ST_REQ: begin
          tmrQ   <= TMR_W'(SETTLE_CYC - 1);
          stateQ <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tmrQ != '0) begin
            tmrQ <= tmrQ - 1'b1;
          end else if (sIdxQ == SIDX_W'(SAMPLES - 1)) begin
            sIdxQ  <= '0;
            stateQ <= ST_EVAL;
          end else begin
            sIdxQ  <= sIdxQ + 1'b1;
            stateQ <= ST_REQ;
          end
        end
        ST_EVAL: stateQ <= ST_CHECK;
        ST_CHECK: begin
          if (fault) begin
            errQ   <= 1'b1;
            stateQ <= ST_IDLE;
          end else if (allDone && !passQ) begin
            passQ  <= 1'b1;
            stateQ <= ST_REQ;
          end else if (allDone) begin
            offCntQ <= offLen;
            stateQ  <= ST_OFFS;
          end else begin
            stateQ <= ST_REQ;
          end
        end
        ST_OFFS: begin
          if (offCntQ != '0) begin
            offCntQ <= offCntQ - 1'b1;
          end else if (fault) begin
            errQ   <= 1'b1;
            stateQ <= ST_IDLE;
          end else begin
            stateQ <= ST_FIN;
          end
        end
        ST_FIN: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign sampleReq = (stateQ == ST_REQ);
  assign done      = (stateQ == ST_FIN);
  assign error     = errQ;

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |=> !sampleReq);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (error && !start) |=> error);
endmodule

// File: rtl/wlEdgeSearch.sv
module wlEdgeSearch
  import wlSearchPkg::*;
#(
  parameter int LANES      = 8,
  parameter int SAMPLES    = 5,
  parameter int SETTLE_CYC = 1250,
  parameter int OFF0       = 39,
  parameter int OFF1       = 32,
  parameter int OFF2       = 42,
  parameter int MT0        = 12,
  parameter int MT1        = 10,
  parameter int MT2        = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [1:0]             gradeSel,
  input  logic [LANES*SET_W-1:0] initDly,
  input  logic [LANES-1:0]       sampleBits,
  output logic                   sampleReq,
  output logic [LANES-1:0]       stepUp,
  output logic [LANES-1:0]       stepDn,
  output logic [LANES*SET_W-1:0] strobeDly,
  output logic [LANES*SET_W-1:0] dataDly,
  output logic                   done,
  output logic                   error
);
  localparam int OFF_A   = (OFF0 > OFF1) ? OFF0 : OFF1;
  localparam int OFF_MAX = (OFF_A > OFF2) ? OFF_A : OFF2;
  localparam int OFF_W   = $clog2(OFF_MAX + 1);

  ctrlStrb_t        strb;
  logic             allDone, fault;
  logic [OFF_W-1:0] offLen;

  wlSearchCtrl #(
    .SAMPLES(SAMPLES), .SETTLE_CYC(SETTLE_CYC), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .allDone(allDone), .fault(fault),
    .offLen(offLen), .strb(strb), .sampleReq(sampleReq), .done(done), .error(error)
  );

  wlSearchDp #(
    .LANES(LANES), .SAMPLES(SAMPLES), .OFF_W(OFF_W),
    .OFF0(OFF0), .OFF1(OFF1), .OFF2(OFF2), .MT0(MT0), .MT1(MT1), .MT2(MT2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .gradeSel(gradeSel), .initFlat(initDly),
    .sampleBits(sampleBits), .allDone(allDone), .fault(fault), .offLen(offLen),
    .stepUp(stepUp), .stepDn(stepDn), .strobeFlat(strobeDly), .dataFlat(dataDly)
  );
endmodule

// File: tb/wlEdgeSearch_tb.sv
module wlEdgeSearch_tb;
  localparam int NL = 8;
  localparam int SW = 10;
  localparam int SETTLE = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      gradeSel = 2'd0;
  logic [NL*SW-1:0] initDly = '0;
  logic [NL-1:0]   sampleBits = '0;
  logic            sampleReq, done, error;
  logic [NL-1:0]   stepUp, stepDn;
  logic [NL*SW-1:0] strobeDly, dataDly;

  int checks = 0, errors = 0, cyc = 0;
  int startA[NL], edgeA[NL], posA[NL];
  bit jitA[NL], phaseA[NL];
  int reqCnt = 0, reqCyc0 = 0, reqCyc1 = 0;

  always #2 clk = ~clk;

  wlEdgeSearch #(.LANES(NL), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .gradeSel(gradeSel), .initDly(initDly),
    .sampleBits(sampleBits), .sampleReq(sampleReq), .stepUp(stepUp), .stepDn(stepDn),
    .strobeDly(strobeDly), .dataDly(dataDly), .done(done), .error(error)
  );

  function automatic int tapMax(int g);
    return (g == 1) ? 10 : (g == 2) ? 13 : 12;
  endfunction
  function automatic int offOf(int g);
    return (g == 1) ? 32 : (g == 2) ? 42 : 39;
  endfunction
  function automatic int topPos(int g);
    return 5 * (tapMax(g) + 1) * 7 - 1;
  endfunction
  function automatic int idxOf(logic [SW-1:0] s, int g);
    int per;
    per = (tapMax(g) + 1) * 7;
    return (int'(s[8:7]) + 2 * int'(s[9])) * per + int'(s[6:3]) * 7 + int'(s[2:0]);
  endfunction
  function automatic logic [SW-1:0] setOf(int idx, int g);
    int per, blk, rem;
    logic [SW-1:0] s;
    per = (tapMax(g) + 1) * 7;
    blk = idx / per;
    rem = idx % per;
    s[9]   = (blk >= 3);
    s[8:7] = (blk >= 3) ? 2'(blk - 2) : 2'(blk);
    s[6:3] = 4'(rem / 7);
    s[2:0] = 3'(rem % 7);
    return s;
  endfunction

  // lane model: position moves only on step pulses
  always @(negedge clk) begin
    cyc++;
    if (sampleReq) begin
      reqCnt++;
      if (reqCnt == 1) reqCyc0 = cyc;
      if (reqCnt == 2) reqCyc1 = cyc;
    end
    for (int l = 0; l < NL; l++) begin
      if (stepUp[l]) posA[l]++;
      if (stepDn[l]) posA[l]--;
      if (sampleReq) phaseA[l] = ~phaseA[l];
      sampleBits[l] = (jitA[l] && posA[l] == edgeA[l]) ? phaseA[l] : (posA[l] >= edgeA[l]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic setLanes(input int s[NL], input int e[NL], input bit j[NL]);
    for (int l = 0; l < NL; l++) begin
      startA[l] = s[l]; edgeA[l] = e[l]; jitA[l] = j[l];
    end
  endtask

  task automatic runSearch(input int g, output int res);
    gradeSel = 2'(g);
    for (int l = 0; l < NL; l++) begin
      posA[l] = startA[l];
      initDly[l*SW +: SW] = setOf(startA[l], g);
    end
    @(negedge clk);
    reqCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    res = 0;
    for (int k = 0; k < 30000 && res == 0; k++) begin
      @(negedge clk);
      if (done) res = 1;
      else if (error) res = 2;
    end
    if (res == 0) chk(1'b0, "R10 completion", 0, 1);
  endtask

  task automatic checkSuccess(input int g, input int res);
    chk(res == 1, "R10 done seen", res, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done width", int'(done), 0);
    for (int l = 0; l < NL; l++) begin
      int exp;
      exp = edgeA[l] + (jitA[l] ? 1 : 0);
      chk(idxOf(strobeDly[l*SW +: SW], g) == exp, "R3 R4 R5 strobe position",
          idxOf(strobeDly[l*SW +: SW], g), exp);
      chk(posA[l] == exp, "R11 pulse-tracked position", posA[l], exp);
      chk(idxOf(dataDly[l*SW +: SW], g) == exp + offOf(g), "R8 data position",
          idxOf(dataDly[l*SW +: SW], g), exp + offOf(g));
    end
  endtask

  task automatic testReset;
    chk(done == 1'b0 && error == 1'b0, "R1 flags", int'({done, error}), 0);
    chk(sampleReq == 1'b0, "R1 sampleReq", int'(sampleReq), 0);
    chk(stepUp == '0 && stepDn == '0, "R1 steps", int'({stepUp, stepDn}), 0);
    chk(strobeDly == '0 && dataDly == '0, "R1 delays", int'(|{strobeDly, dataDly}), 0);
  endtask

  task automatic testGrade0Mixed;
    int res;
    setLanes('{20, 5, 40, 100, 60, 10, 33, 140}, '{10, 30, 25, 90, 60, 11, 33, 130},
             '{0, 0, 1, 0, 0, 0, 1, 0});
    runSearch(0, res);
    checkSuccess(0, res);
  endtask

  task automatic testGrade1Carry;
    int res;
    setLanes('{70, 90, 150, 160, 225, 240, 231, 305}, '{76, 77, 153, 154, 231, 232, 230, 300},
             '{0, 0, 0, 1, 0, 0, 0, 0});
    runSearch(1, res);
    checkSuccess(1, res);
  endtask

  task automatic testGrade2;
    int res;
    setLanes('{300, 290, 294, 95, 55, 405, 198, 0}, '{294, 295, 293, 100, 50, 400, 200, 3},
             '{0, 0, 0, 0, 1, 0, 0, 0});
    runSearch(2, res);
    checkSuccess(2, res);
  endtask

  task automatic testReqCount;
    int res;
    setLanes('{8, 50, 90, 120, 200, 260, 300, 400}, '{9, 51, 91, 121, 201, 261, 301, 401},
             '{0, 0, 0, 0, 0, 0, 0, 0});
    runSearch(0, res);
    chk(res == 1, "R2 run completes", res, 1);
    chk(reqCnt == 15, "R2 request count", reqCnt, 15);
    chk(reqCyc1 - reqCyc0 == SETTLE + 1, "R2 request spacing", reqCyc1 - reqCyc0, SETTLE + 1);
  endtask

  task automatic checkErrorHold;
    for (int k = 0; k < 10; k++) @(negedge clk);
    chk(error == 1'b1 && done == 1'b0, "R10 error held", int'({error, done}), 2);
  endtask

  task automatic testUnderflow;
    int res;
    setLanes('{20, 30, 40, 4, 60, 70, 80, 90}, '{10, 31, 40, 0, 55, 71, 80, 85},
             '{0, 0, 0, 0, 0, 0, 0, 0});
    runSearch(0, res);
    chk(res == 2, "R6 underflow error", res, 2);
    chk(idxOf(strobeDly[3*SW +: SW], 0) == 0, "R6 lane stops at zero",
        idxOf(strobeDly[3*SW +: SW], 0), 0);
    checkErrorHold();
  endtask

  task automatic testOverflow;
    int res;
    setLanes('{20, 30, 40, 50, 60, 380, 80, 90}, '{22, 31, 42, 51, 60, 1000, 81, 93},
             '{0, 0, 0, 0, 0, 0, 0, 0});
    runSearch(1, res);
    chk(res == 2, "R7 overflow error", res, 2);
    chk(idxOf(strobeDly[5*SW +: SW], 1) == topPos(1), "R7 lane stops at top",
        idxOf(strobeDly[5*SW +: SW], 1), topPos(1));
    checkErrorHold();
  endtask

  task automatic testDataOverflow;
    int res;
    setLanes('{20, 455, 40, 50, 60, 70, 80, 90}, '{22, 460, 42, 51, 60, 71, 81, 93},
             '{0, 0, 0, 0, 0, 0, 0, 0});
    runSearch(2, res);
    chk(res == 2, "R9 data offset overflow error", res, 2);
    chk(idxOf(strobeDly[1*SW +: SW], 2) == 460, "R9 strobe still found",
        idxOf(strobeDly[1*SW +: SW], 2), 460);
  endtask

  task automatic testRecovery;
    int res;
    setLanes('{12, 25, 44, 60, 7, 100, 150, 201}, '{15, 20, 44, 66, 9, 98, 151, 200},
             '{0, 0, 0, 0, 0, 0, 0, 1});
    @(negedge clk);
    chk(error == 1'b1, "R10 error before restart", int'(error), 1);
    runSearch(0, res);
    chk(error == 1'b0, "R10 error cleared by start", int'(error), 0);
    checkSuccess(0, res);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      posA[l] = 0; edgeA[l] = 1; jitA[l] = 0; phaseA[l] = 0; startA[l] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGrade0Mixed();
    testGrade1Carry();
    testGrade2();
    testReqCount();
    testUnderflow();
    testOverflow();
    testDataOverflow();
    testRecovery();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule